// File: doc/BRIEF.md
# Edge and Gate Pulse Accumulator

This block counts activity on one asynchronous input pin into a 16-bit register. It has two modes. In event mode it adds one for each chosen transition of the pin. In gated mode it adds one for each prescaled tick that arrives while the pin holds its active level. The pin passes through a two-flop synchronizer before any edge is detected. The block raises two sticky flags: an overflow flag when an increment wraps the counter to zero, and an input flag. The input flag is set by each counted event in event mode, and by the trailing edge of the gate in gated mode. An interrupt line combines the flags with per-flag enable bits.

Software reaches the counter, the flags and the interrupt enables through a small register port. The port accepts byte and word transfers. A word transfer moves all 16 counter bits in a single cycle, so a read never mixes the bytes of two different counts. A flag is cleared by writing a one to its bit, and only while a timer or accumulator enable is set. In fast-clear mode, any read or write to the counter clears both flags. The gate tracker is a three-state machine. OFF means the accumulator is disabled. IDLE means it is enabled with no gate open. OPEN means a gate is in progress. Its transitions are: OFF to IDLE or OPEN on enable; IDLE to OPEN at the leading edge of the gate; OPEN to IDLE at the trailing edge, which also raises the input flag; and any state to OFF when the enable drops.

Top module: `pulse_acc_top`

## Requirements
- R1: After reset the counter, both flags, the interrupt enables and `irq` are all zero.
- R2: In event mode (`gated_mode`=0), `edge_sel` chooses which pin edges are counted: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. A pin change made before clock edge k is counted in the counter value seen after edge k+2.
- R3: In gated mode, the counter adds one on every cycle with `tick`=1 in which the synchronized pin is at its active level. `edge_sel[0]`=1 makes high the active level; `edge_sel[0]`=0 makes low the active level.
- R4: An increment from 0xFFFF to 0x0000 sets the overflow flag, which is bit 1 of the flag register.
- R5: In event mode, each counted edge sets the input flag, which is bit 0 of the flag register.
- R6: In gated mode, the input flag is set when the gate goes from active to inactive (OPEN to IDLE). The leading edge of the gate does not set it.
- R7: With `acc_en`=0 the counter does not change on its own, and neither flag is set.
- R8: A write to address 2 clears each flag whose data bit is 1, but only while `timer_en` or `acc_en` is 1. Data bits that are 0 leave their flags as they are.
- R9: With `fast_clr`=1, any read or write to address 0 or 1 clears both flags.
- R10: Counter writes take priority over increments. A word write to address 0 loads all 16 bits. A byte write to address 0 loads the high byte, and a byte write to address 1 loads the low byte. A value loaded by a write never sets the overflow flag.
- R11: `bus_rdata` depends on the address. Address 0 with `bus_word`=1 returns the full count. Address 0 byte returns the high byte and address 1 returns the low byte, each zero-extended. Address 2 returns the flags and address 3 returns the interrupt enables, in bits [1:0].
- R12: `irq` is 1 exactly when some flag is set and its enable bit (written at address 3, same bit positions as the flags) is also 1.
- R13: If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous input pin |
| timer_en | input | 1 | Timer enable (allows flag clears) |
| acc_en | input | 1 | Accumulator enable |
| gated_mode | input | 1 | 0 event mode, 1 gated mode |
| edge_sel | input | 2 | Edge select / gate polarity |
| fast_clr | input | 1 | Fast flag-clear mode |
| tick | input | 1 | Prescaled clock tick |
| bus_addr | input | 2 | 0 count high/word, 1 count low, 2 flags, 3 interrupt enables |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 selects a 16-bit transfer |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
A pin change appears as a counted edge two clock edges after the first one that samples it. The counter and flags then update on the third edge. Register writes and tick-driven increments appear one edge after the cycle that presents them. `bus_rdata` and `irq` follow register state within the same cycle. The bench model keeps a three-deep queue of pin samples and applies every update at the same clock edge as the design. It compares both outputs at each falling edge, before the next stimulus is driven, so every result is checked on exactly the cycle it is due.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        GS_OFF  = 2'd0,
        GS_IDLE = 2'd1,
        GS_OPEN = 2'd2
    } gate_st_e;

    localparam logic [1:0] ADR_CNT_HI = 2'd0;
    localparam logic [1:0] ADR_CNT_LO = 2'd1;
    localparam logic [1:0] ADR_FLAGS  = 2'd2;
    localparam logic [1:0] ADR_IEN    = 2'd3;

    localparam int NFLAGS   = 2;
    localparam int FLG_EDGE = 0;
    localparam int FLG_OVF  = 1;
endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic lvl,
    output logic rise,
    output logic fall
);
    // STAGES flops resynchronise the pin; one more holds the previous level
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin_in};
    end

    assign lvl  = sh[STAGES-1];
    assign rise =  sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/pacc_gate_fsm.sv
module pacc_gate_fsm
    import pacc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acc_en,
    input  logic     gated,
    input  logic     active,
    output gate_st_e state,
    output logic     trail
);
    gate_st_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GS_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt   = state;
        trail = 1'b0;
        unique case (state)
            GS_OFF: begin
                if (acc_en) nxt = (gated && active) ? GS_OPEN : GS_IDLE;
            end
            GS_IDLE: begin
                if (!acc_en)               nxt = GS_OFF;
                else if (gated && active)  nxt = GS_OPEN;
            end
            GS_OPEN: begin
                if (!acc_en) begin
                    nxt = GS_OFF;
                end else if (!gated) begin
                    nxt = GS_IDLE;
                end else if (!active) begin
                    nxt   = GS_IDLE;
                    trail = 1'b1;
                end
            end
            default: nxt = GS_OFF;
        endcase
    end
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] ld_mask,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= (cnt & ~ld_mask) | (ld_val & ld_mask);
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign wrap = inc && !load && (cnt == ALL_ONES);
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top
    import pacc_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             timer_en,
    input  logic             acc_en,
    input  logic             gated_mode,
    input  logic [1:0]       edge_sel,
    input  logic             fast_clr,
    input  logic             tick,
    input  logic [1:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_word,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    localparam logic [CNT_W-1:0] HI_MASK = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
    localparam logic [CNT_W-1:0] LO_MASK = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

    logic              lvl, rise, fall, active, evt, inc, trail, wrap;
    logic              cnt_acc, load;
    logic [CNT_W-1:0]  ld_mask, ld_val, cnt;
    logic [NFLAGS-1:0] flags, ien, set_vec, clr_vec;
    gate_st_e          gstate;

    pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign active = edge_sel[0] ? lvl : ~lvl;
    assign evt    = !gated_mode && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
    assign inc    = acc_en && (evt || (gated_mode && tick && active));

    pacc_gate_fsm u_gate (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .gated(gated_mode),
        .active(active), .state(gstate), .trail(trail)
    );

    // counter access decode: word at address 0, bytes at 0 (high) and 1 (low)
    assign cnt_acc = (bus_rd || bus_wr) && (bus_addr == ADR_CNT_HI || bus_addr == ADR_CNT_LO);
    assign load    = bus_wr && (bus_addr == ADR_CNT_HI || bus_addr == ADR_CNT_LO);

    always_comb begin
        if (bus_addr == ADR_CNT_LO) begin
            ld_mask = LO_MASK;
            ld_val  = {{BYTE_W{1'b0}}, bus_wdata[BYTE_W-1:0]};
        end else if (bus_word) begin
            ld_mask = '1;
            ld_val  = bus_wdata;
        end else begin
            ld_mask = HI_MASK;
            ld_val  = {bus_wdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
        end
    end

    pacc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .load(load),
        .ld_mask(ld_mask), .ld_val(ld_val), .cnt(cnt), .wrap(wrap)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLG_EDGE] = acc_en && (evt || trail);
        set_vec[FLG_OVF]  = wrap;
        clr_vec           = '0;
        if (bus_wr && bus_addr == ADR_FLAGS && (timer_en || acc_en))
            clr_vec = bus_wdata[NFLAGS-1:0];
        if (fast_clr && cnt_acc)
            clr_vec = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            ien   <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
            if (bus_wr && bus_addr == ADR_IEN) ien <= bus_wdata[NFLAGS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CNT_HI: bus_rdata = bus_word ? cnt : {{BYTE_W{1'b0}}, cnt[CNT_W-1:BYTE_W]};
            ADR_CNT_LO: bus_rdata = {{BYTE_W{1'b0}}, cnt[BYTE_W-1:0]};
            ADR_FLAGS:  bus_rdata[NFLAGS-1:0] = flags;
            ADR_IEN:    bus_rdata[NFLAGS-1:0] = ien;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = |(flags & ien);
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
    parameter int CNT_W  = 16,
    parameter int NFLAGS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              timer_en,
    input logic              fast_clr,
    input logic              inc,
    input logic              load,
    input logic              cnt_acc,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  ld_mask,
    input logic [CNT_W-1:0]  ld_val,
    input logic [NFLAGS-1:0] flags,
    input logic [NFLAGS-1:0] set_vec
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R4: an increment out of the all-ones count leaves the overflow flag set
    a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && cnt == TOP) |=> (flags[1] && cnt == '0));

    // R7: with the accumulator disabled and no write, the count holds
    a_r7_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !load) |=> $stable(cnt));

    // R10: a write beats a concurrent increment
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == (($past(cnt) & ~$past(ld_mask)) | ($past(ld_val) & $past(ld_mask))));

    // R8: with both enables low and no fast clear, no flag goes from 1 to 0
    a_r8_no_clear_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_en && !acc_en && !fast_clr) |=> (($past(flags) & ~flags) == '0));

    // R9: a counter access in fast-clear mode empties every flag not being set
    a_r9_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_clr && cnt_acc) |=> ((flags & ~$past(set_vec)) == '0));

    // R7: nothing sets a flag while disabled, except a wrap, which needs an increment
    a_r7_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> set_vec == '0);
endmodule

bind pulse_acc_top pacc_checker #(.CNT_W(CNT_W), .NFLAGS(pacc_pkg::NFLAGS)) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .timer_en(timer_en),
    .fast_clr(fast_clr), .inc(inc), .load(load), .cnt_acc(cnt_acc),
    .cnt(cnt), .ld_mask(ld_mask), .ld_val(ld_val), .flags(flags), .set_vec(set_vec)
);

// File: tb/pulse_acc_top_tb_top.sv
`timescale 1ns/1ps
module pulse_acc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0, timer_en = 1'b0, acc_en = 1'b0, gated_mode = 1'b0;
    logic [1:0]  edge_sel = 2'b01;
    logic        fast_clr = 1'b0, tick = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b1;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;

    int    n_checks = 0, n_fail = 0, cyc = 0;
    string phase = "R1 reset";

    always #4 clk = ~clk;

    pulse_acc_top dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_en(timer_en),
        .acc_en(acc_en), .gated_mode(gated_mode), .edge_sel(edge_sel),
        .fast_clr(fast_clr), .tick(tick), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    int m_cnt, m_flags, m_ien;
    bit m_open;
    int pin_q[$] = '{0, 0, 0};

    always @(posedge clk) begin
        int lvl, prv, act, ev, inc_v, trl, ld, acc, se, so, clr;
        if (!rst_n) begin
            m_cnt = 0; m_flags = 0; m_ien = 0; m_open = 0;
            pin_q = '{0, 0, 0};
        end else begin
            lvl   = pin_q[1];
            prv   = pin_q[2];
            act   = edge_sel[0] ? lvl : !lvl;
            ev    = !gated_mode && ((edge_sel[0] && lvl && !prv) || (edge_sel[1] && !lvl && prv)); // R2
            inc_v = acc_en && (ev || (gated_mode && tick && act));                               // R3 R7
            trl   = m_open && acc_en && gated_mode && !act;                                      // R6
            acc   = (bus_rd || bus_wr) && bus_addr < 2;
            ld    = bus_wr && bus_addr < 2;
            se    = acc_en && (ev || trl);                                                       // R5
            so    = inc_v && !ld && m_cnt == 16'hFFFF;                                           // R4
            clr   = 0;
            if (bus_wr && bus_addr == 2 && (timer_en || acc_en)) clr = bus_wdata[1:0];           // R8
            if (fast_clr && acc) clr = 3;                                                        // R9
            if (ld) begin                                                                        // R10
                if (bus_addr == 1)  m_cnt = (m_cnt & 16'hFF00) | bus_wdata[7:0];
                else if (bus_word)  m_cnt = bus_wdata;
                else                m_cnt = (m_cnt & 16'h00FF) | (bus_wdata[7:0] << 8);
            end else if (inc_v) m_cnt = (m_cnt + 1) & 16'hFFFF;
            m_flags = (m_flags & ~clr & 3) | se | (so << 1);                                     // R13
            if (bus_wr && bus_addr == 3) m_ien = bus_wdata[1:0];
            m_open = acc_en && gated_mode && act;
            pin_q.push_front(int'(pin_in));
            void'(pin_q.pop_back());
        end
    end

    function automatic int exp_rdata();                                                          // R11
        case (bus_addr)
            2'd0:    return bus_word ? m_cnt : (m_cnt >> 8);
            2'd1:    return m_cnt & 8'hFF;
            2'd2:    return m_flags;
            default: return m_ien;
        endcase
    endfunction

    task automatic check_eq(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // compare every cycle on the falling edge, before new stimulus
    always @(negedge clk) begin
        cyc++;
        check_eq({phase, " rdata"}, int'(bus_rdata), exp_rdata());
        check_eq({phase, " R12 irq"}, int'(irq), int'((m_flags & m_ien) != 0));
    end

    // ---------------- stimulus ----------------
    task automatic step(int n = 1);
        repeat (n) begin
            @(negedge clk); #1;
            bus_rd = 0; bus_wr = 0;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d, logic w = 1'b1);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1; bus_rd = 0;
    endtask

    task automatic rd(logic [1:0] a, logic w = 1'b1);
        @(negedge clk); #1;
        bus_addr = a; bus_word = w; bus_rd = 1; bus_wr = 0;
    endtask

    task automatic wiggle(int n, int prob, bit ticks);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            bus_rd = 0; bus_wr = 0;
            if (($urandom % prob) == 0) pin_in = ~pin_in;
            tick = ticks && (($urandom % 3) == 0);
        end
        tick = 0;
    endtask

    initial begin
        step(4);
        rst_n = 1;
        step(2);
        check_eq("R1 count after reset", int'(bus_rdata), 0);
        rd(2'd2); step(1);
        rd(2'd3); step(1);

        acc_en = 1; timer_en = 1;
        phase = "R2 R5 rising";  edge_sel = 2'b01; bus_addr = 0; bus_word = 1; wiggle(40, 3, 0);
        phase = "R2 R5 falling"; edge_sel = 2'b10; wiggle(40, 3, 0);
        phase = "R2 R5 both";    edge_sel = 2'b11; wiggle(40, 2, 0);
        phase = "R2 none";       edge_sel = 2'b00; wiggle(30, 2, 0);

        phase = "R12 enables";   wr(2'd3, 16'h0003); step(1);
        rd(2'd2); step(2);
        phase = "R8 clear";      wr(2'd2, 16'h0000); step(1);
        wr(2'd2, 16'h0001); step(1); rd(2'd2); step(1);
        edge_sel = 2'b01; wiggle(10, 2, 0);
        acc_en = 0; timer_en = 0; step(4);
        phase = "R7 R8 disabled"; wr(2'd2, 16'h0003); step(1);
        wiggle(20, 2, 1); rd(2'd2); step(2);
        timer_en = 1; wr(2'd2, 16'h0003); step(1); rd(2'd2); step(1);
        check_eq("R8 flags cleared via timer enable", int'(bus_rdata), 0);

        acc_en = 1;
        phase = "R4 overflow";  wr(2'd0, 16'hFFFD); step(1); bus_addr = 0; wiggle(30, 2, 0);
        rd(2'd2); step(2);
        wr(2'd2, 16'h0003); step(1);
        phase = "R10 load wins";
        for (int i = 0; i < 30; i++) begin
            wr(2'(i % 2), (i % 3 == 0) ? 16'hFFFF : 16'(i * 97), 1'(i % 4 != 1));
            pin_in = ~pin_in;
        end
        step(4); rd(2'd2); step(1);
        wr(2'd0, 16'h12FF); step(1); rd(2'd0, 1'b0); step(1);
        check_eq("R11 high byte", int'(bus_rdata), 16'h0012);
        rd(2'd1); step(1);
        check_eq("R11 low byte", int'(bus_rdata), 16'h00FF);

        phase = "R9 R13 fast clear"; edge_sel = 2'b11; wiggle(10, 1, 0);
        fast_clr = 1;
        for (int i = 0; i < 20; i++) begin
            if (i % 2 == 0) rd(2'(i % 4 == 0 ? 0 : 1)); else step(1);
            pin_in = ~pin_in;
        end
        step(3); rd(2'd0); step(1); rd(2'd2); step(1);
        check_eq("R9 flags after fast clear", int'(bus_rdata), 0);
        fast_clr = 0;

        phase = "R3 R6 gated high"; gated_mode = 1; edge_sel = 2'b01; wr(2'd2, 16'h3); step(1);
        bus_addr = 0; wiggle(80, 6, 1);
        phase = "R3 R6 gated low";  edge_sel = 2'b00; wiggle(80, 6, 1);
        rd(2'd2); step(2);
        phase = "R7 gated frozen"; acc_en = 0; bus_addr = 0; wiggle(40, 4, 1);
        gated_mode = 0; wiggle(30, 2, 0);
        acc_en = 1; phase = "R3 re-enable"; gated_mode = 1; wiggle(30, 5, 1);
        step(5);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule